// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block keeps the transfer state for a four-channel DMA unit. Each channel has a 16-bit current address, a 16-bit current count, base copies of both for reload, an 8-bit page register, two mode bits and a mask bit. A load port writes the channel registers, and a mask port sets or clears one channel's mask. Each transfer strobe names a channel. If that channel is live, the block advances the channel's address, decrements its count, and emits the 24-bit physical memory address for that transfer one cycle later.

The stored count is one less than the number of transfers. Terminal count is reached when a transfer is made with the count at zero. At that point the block pulses a terminal-count output and sets the channel's sticky status bit. The channel then either reloads from its base copies (auto-initialize) or masks itself. Byte channels form 64 KiB pages. Word channels shift the address left by one and form 128 KiB pages. The 16-bit address always wraps inside its page. Arbitration, bus handshakes and the data path live elsewhere.

A read port returns one channel's current address and count, registered. Software reads the count and adds one (with 16-bit wrap) to get the residue.

Top module: `dma_xfer_engine`

## Requirements
- R1: After synchronous reset every channel is masked (mask_o = 4'hF). Addresses, counts, pages, mode bits, tc_status_o and all pulse outputs are zero.
- R2: A load (ld_we_i) with ld_sel_i = 0 writes the current and base address. ld_sel_i = 1 writes the current and base count and clears that channel's sticky status bit. ld_sel_i = 2 writes the page from ld_data_i[7:0]. ld_sel_i = 3 writes the mode from ld_data_i, where bit 4 is auto-initialize and bit 5 is decrement.
- R3: On a byte channel (a WORD_CHANNELS bit that is 0; default channels 0 and 1), the physical address is {page[7:0], address[15:0]}.
- R4: On a word channel (default channels 2 and 3), the physical address is {page[7:1], address[15:0], 1'b0}. Page bit 0 is ignored.
- R5: Each accepted transfer adds one to the address, or subtracts one when mode bit 5 is set. The address wraps modulo 2^16 and never changes the page.
- R6: A loaded count N gives exactly N+1 transfers before terminal count, so 0 gives a single transfer. After terminal count without reload, the count reads 0xFFFF.
- R7: Terminal count drives tc_o high for one cycle, together with that transfer's phys_valid_o, with tc_ch_o naming the channel. It also sets tc_status_o for that channel.
- R8: Without auto-initialize, terminal count sets the channel's mask bit. Later strobes to that channel produce no phys_valid_o and change neither its address nor its count.
- R9: With auto-initialize, terminal count copies the base address and base count into the current registers, and the mask stays clear.
- R10: mask_we_i sets (mask_set_i = 1) or clears the mask of mask_ch_i. A strobe to a masked channel is ignored. A mask write takes priority over a same-cycle terminal-count mask.
- R11: A strobe to a channel that is being loaded in the same cycle is discarded. The load takes effect, and no phys_valid_o is produced.
- R12: phys_valid_o, phys_addr_o, xfer_ch_o, tc_o and tc_ch_o appear on the cycle after the strobe. rd_addr_o and rd_cnt_o show channel rd_ch_i's state one cycle after it is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we_i | input | 1 | Register load strobe |
| ld_sel_i | input | 2 | Load target: 0 address, 1 count, 2 page, 3 mode |
| ld_ch_i | input | 2 | Channel being loaded |
| ld_data_i | input | 16 | Load data |
| mask_we_i | input | 1 | Mask write strobe |
| mask_ch_i | input | 2 | Channel whose mask is written |
| mask_set_i | input | 1 | 1 masks, 0 unmasks |
| xfer_i | input | 1 | Transfer strobe |
| xfer_ch_i | input | 2 | Channel granted the transfer |
| rd_ch_i | input | 2 | Channel selected for readback |
| phys_valid_o | output | 1 | A transfer was accepted last cycle |
| phys_addr_o | output | 24 | Physical address of that transfer |
| xfer_ch_o | output | 2 | Channel of that transfer |
| tc_o | output | 1 | Terminal-count pulse |
| tc_ch_o | output | 2 | Channel that reached terminal count |
| tc_status_o | output | 4 | Sticky terminal-count bits |
| mask_o | output | 4 | Channel mask bits |
| rd_addr_o | output | 16 | Current address of the selected channel |
| rd_cnt_o | output | 16 | Current count of the selected channel |

## Verification
The bench tests the minus-one count at both ends. A loaded count of 2 must give three transfers. A loaded count of 0 must give terminal count on the first strobe. An off-by-one design fires early or late, or reads back something other than 0xFFFF. Address wrap is tested upward on a word channel and downward on a byte channel, where a design that carries into the page shows a changed upper byte. Word mapping uses an odd page, which exposes a design that passes page bit 0 or fails to shift the address. The bench also covers auto-reload versus self-masking, and a load colliding with a strobe on the same channel, where a wrong priority shows up as a spurious physical address or a lost load.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_PAGE = 2'd2,
    SEL_MODE = 2'd3
  } ld_sel_e;

  localparam int MODE_AUTO_BIT = 4;
  localparam int MODE_DEC_BIT  = 5;
endpackage

// File: rtl/dma_chan_state.sv
module dma_chan_state
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_hit,
  input  logic [1:0]        ld_sel,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              xfer_hit,
  input  logic              mask_hit,
  input  logic              mask_set,
  output logic              go,
  output logic              tc_hit,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic [PAGE_W-1:0] page,
  output logic              mask,
  output logic              tc_stat
);
  logic [ADDR_W-1:0] base_addr;
  logic [CNT_W-1:0]  base_cnt;
  logic              auto_q;
  logic              dec_q;
  logic [ADDR_W-1:0] next_addr;

  // Transfer qualification: masked channels and colliding loads drop the strobe.
  assign go        = xfer_hit && !mask && !ld_hit;
  assign tc_hit    = go && (cur_cnt == '0);
  assign next_addr = dec_q ? (cur_addr - 1'b1) : (cur_addr + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      page      <= '0;
      auto_q    <= 1'b0;
      dec_q     <= 1'b0;
      mask      <= 1'b1;
      tc_stat   <= 1'b0;
    end else begin
      if (ld_hit) begin
        case (ld_sel_e'(ld_sel))
          SEL_ADDR: begin
            base_addr <= ld_data[ADDR_W-1:0];
            cur_addr  <= ld_data[ADDR_W-1:0];
          end
          SEL_CNT: begin
            base_cnt <= ld_data[CNT_W-1:0];
            cur_cnt  <= ld_data[CNT_W-1:0];
            tc_stat  <= 1'b0;
          end
          SEL_PAGE: page <= ld_data[PAGE_W-1:0];
          default: begin
            auto_q <= ld_data[MODE_AUTO_BIT];
            dec_q  <= ld_data[MODE_DEC_BIT];
          end
        endcase
      end else if (go) begin
        if (tc_hit && auto_q) begin
          cur_addr <= base_addr;
          cur_cnt  <= base_cnt;
        end else begin
          cur_addr <= next_addr;
          cur_cnt  <= cur_cnt - 1'b1;
        end
      end
      if (tc_hit) begin
        tc_stat <= 1'b1;
        if (!auto_q) mask <= 1'b1;
      end
      if (mask_hit) mask <= mask_set;
    end
  end
endmodule

// File: rtl/dma_phys_map.sv
module dma_phys_map #(
  parameter int ADDR_W  = 16,
  parameter int PAGE_W  = 8,
  parameter bit WORD_CH = 1'b0,
  localparam int PHYS_W = ADDR_W + PAGE_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] page,
  output logic [PHYS_W-1:0] phys
);
  generate
    if (WORD_CH) begin : g_word
      // Page LSB is replaced by the shifted address; A0 is forced low.
      assign phys = {page[PAGE_W-1:1], addr, page[0] & 1'b0};
    end else begin : g_byte
      assign phys = {page, addr};
    end
  endgenerate
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 8,
  parameter int DATA_W = 16,
  parameter logic [NUM_CH-1:0] WORD_CHANNELS = 4'b1100,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int PHYS_W = ADDR_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we_i,
  input  logic [1:0]        ld_sel_i,
  input  logic [CH_W-1:0]   ld_ch_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic              mask_we_i,
  input  logic [CH_W-1:0]   mask_ch_i,
  input  logic              mask_set_i,
  input  logic              xfer_i,
  input  logic [CH_W-1:0]   xfer_ch_i,
  input  logic [CH_W-1:0]   rd_ch_i,
  output logic              phys_valid_o,
  output logic [PHYS_W-1:0] phys_addr_o,
  output logic [CH_W-1:0]   xfer_ch_o,
  output logic              tc_o,
  output logic [CH_W-1:0]   tc_ch_o,
  output logic [NUM_CH-1:0] tc_status_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [CNT_W-1:0]  rd_cnt_o
);
  logic [NUM_CH-1:0] go_vec;
  logic [NUM_CH-1:0] tc_vec;
  logic [ADDR_W-1:0] addr_a [NUM_CH];
  logic [CNT_W-1:0]  cnt_a  [NUM_CH];
  logic [PAGE_W-1:0] page_a [NUM_CH];
  logic [PHYS_W-1:0] phys_a [NUM_CH];

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dma_chan_state #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)
      ) u_state (
        .clk      (clk),
        .rst      (rst),
        .ld_hit   (ld_we_i && (ld_ch_i == CH_W'(c))),
        .ld_sel   (ld_sel_i),
        .ld_data  (ld_data_i),
        .xfer_hit (xfer_i && (xfer_ch_i == CH_W'(c))),
        .mask_hit (mask_we_i && (mask_ch_i == CH_W'(c))),
        .mask_set (mask_set_i),
        .go       (go_vec[c]),
        .tc_hit   (tc_vec[c]),
        .cur_addr (addr_a[c]),
        .cur_cnt  (cnt_a[c]),
        .page     (page_a[c]),
        .mask     (mask_o[c]),
        .tc_stat  (tc_status_o[c])
      );

      dma_phys_map #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WORD_CH(WORD_CHANNELS[c])
      ) u_map (
        .addr (addr_a[c]),
        .page (page_a[c]),
        .phys (phys_a[c])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_valid_o <= 1'b0;
      phys_addr_o  <= '0;
      xfer_ch_o    <= '0;
      tc_o         <= 1'b0;
      tc_ch_o      <= '0;
      rd_addr_o    <= '0;
      rd_cnt_o     <= '0;
    end else begin
      phys_valid_o <= |go_vec;
      tc_o         <= |tc_vec;
      xfer_ch_o    <= xfer_ch_i;
      tc_ch_o      <= xfer_ch_i;
      if (|go_vec) phys_addr_o <= phys_a[xfer_ch_i];
      rd_addr_o    <= addr_a[rd_ch_i];
      rd_cnt_o     <= cnt_a[rd_ch_i];
    end
  end
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int PHYS_W = 24,
  parameter logic [NUM_CH-1:0] WORD_CHANNELS = 4'b1100
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_we_i,
  input logic [CH_W-1:0]   ld_ch_i,
  input logic              xfer_i,
  input logic [CH_W-1:0]   xfer_ch_i,
  input logic              phys_valid_o,
  input logic [PHYS_W-1:0] phys_addr_o,
  input logic [CH_W-1:0]   xfer_ch_o,
  input logic              tc_o,
  input logic [CH_W-1:0]   tc_ch_o,
  input logic [NUM_CH-1:0] tc_status_o,
  input logic [NUM_CH-1:0] mask_o
);
  assert_tc_with_xfer_R7: assert property (@(posedge clk) disable iff (rst)
    tc_o |-> (phys_valid_o && (tc_ch_o == xfer_ch_o)));

  assert_tc_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    tc_o |-> tc_status_o[tc_ch_o]);

  assert_masked_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (xfer_i && mask_o[xfer_ch_i]) |=> !phys_valid_o);

  assert_load_priority_R11: assert property (@(posedge clk) disable iff (rst)
    (xfer_i && ld_we_i && (ld_ch_i == xfer_ch_i)) |=> !phys_valid_o);

  assert_live_xfer_R12: assert property (@(posedge clk) disable iff (rst)
    (xfer_i && !mask_o[xfer_ch_i] && !(ld_we_i && (ld_ch_i == xfer_ch_i)))
      |=> (phys_valid_o && (xfer_ch_o == $past(xfer_ch_i))));

  assert_word_even_R4: assert property (@(posedge clk) disable iff (rst)
    (phys_valid_o && WORD_CHANNELS[xfer_ch_o]) |-> !phys_addr_o[0]);

  assert_valid_needs_strobe_R12: assert property (@(posedge clk) disable iff (rst)
    phys_valid_o |-> $past(xfer_i));
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(
  .NUM_CH(NUM_CH), .CH_W(CH_W), .PHYS_W(PHYS_W), .WORD_CHANNELS(WORD_CHANNELS)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ld_we_i      (ld_we_i),
  .ld_ch_i      (ld_ch_i),
  .xfer_i       (xfer_i),
  .xfer_ch_i    (xfer_ch_i),
  .phys_valid_o (phys_valid_o),
  .phys_addr_o  (phys_addr_o),
  .xfer_ch_o    (xfer_ch_o),
  .tc_o         (tc_o),
  .tc_ch_o      (tc_ch_o),
  .tc_status_o  (tc_status_o),
  .mask_o       (mask_o)
);

// File: tb/dma_xfer_engine_tb.sv
module dma_xfer_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_we_i = 1'b0;
  logic [1:0]  ld_sel_i = '0;
  logic [1:0]  ld_ch_i = '0;
  logic [15:0] ld_data_i = '0;
  logic        mask_we_i = 1'b0;
  logic [1:0]  mask_ch_i = '0;
  logic        mask_set_i = 1'b0;
  logic        xfer_i = 1'b0;
  logic [1:0]  xfer_ch_i = '0;
  logic [1:0]  rd_ch_i = '0;
  logic        phys_valid_o;
  logic [23:0] phys_addr_o;
  logic [1:0]  xfer_ch_o;
  logic        tc_o;
  logic [1:0]  tc_ch_o;
  logic [3:0]  tc_status_o;
  logic [3:0]  mask_o;
  logic [15:0] rd_addr_o;
  logic [15:0] rd_cnt_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dma_xfer_engine u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] word_phys(input logic [7:0] pg, input logic [15:0] a);
    return {pg[7:1], a, 1'b0};
  endfunction

  task automatic load(input logic [1:0] ch, input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    ld_we_i = 1'b1; ld_ch_i = ch; ld_sel_i = sel; ld_data_i = d;
    @(negedge clk);
    ld_we_i = 1'b0;
  endtask

  task automatic set_mask(input logic [1:0] ch, input logic v);
    @(negedge clk);
    mask_we_i = 1'b1; mask_ch_i = ch; mask_set_i = v;
    @(negedge clk);
    mask_we_i = 1'b0;
  endtask

  task automatic xfer(input logic [1:0] ch, input bit exp_v, input logic [23:0] exp_a,
                      input bit exp_tc, input string tag);
    @(negedge clk);
    xfer_i = 1'b1; xfer_ch_i = ch;
    @(negedge clk);
    xfer_i = 1'b0;
    chk(phys_valid_o == exp_v, {tag, " valid"}, 32'(phys_valid_o), 32'(exp_v));
    if (exp_v) begin
      chk(phys_addr_o == exp_a, {tag, " addr"}, 32'(phys_addr_o), 32'(exp_a));
      chk(xfer_ch_o == ch, {tag, " chan"}, 32'(xfer_ch_o), 32'(ch));
    end
    chk(tc_o == exp_tc, {tag, " tc"}, 32'(tc_o), 32'(exp_tc));
    if (exp_tc) chk(tc_ch_o == ch, {tag, " tc_ch"}, 32'(tc_ch_o), 32'(ch));
  endtask

  task automatic readback(input logic [1:0] ch, input logic [15:0] ea, input logic [15:0] ec,
                          input string tag);
    @(negedge clk);
    rd_ch_i = ch;
    @(negedge clk);
    chk(rd_addr_o == ea, {tag, " R12 rd_addr"}, 32'(rd_addr_o), 32'(ea));
    chk(rd_cnt_o == ec, {tag, " R12 rd_cnt"}, 32'(rd_cnt_o), 32'(ec));
  endtask

  task automatic t_reset();
    chk(mask_o == 4'hF, "R1 mask", 32'(mask_o), 32'hF);
    chk(tc_status_o == 4'h0, "R1 status", 32'(tc_status_o), 0);
    chk(phys_valid_o == 1'b0, "R1 valid", 32'(phys_valid_o), 0);
    chk(tc_o == 1'b0, "R1 tc", 32'(tc_o), 0);
    readback(2'd1, 16'h0000, 16'h0000, "R1");
  endtask

  task automatic t_byte();
    load(0, 2, 16'h0012); load(0, 0, 16'h3456); load(0, 1, 16'h0002); load(0, 3, 16'h0000);
    readback(0, 16'h3456, 16'h0002, "R2");
    set_mask(0, 1'b0);
    chk(mask_o[0] == 1'b0, "R10 unmask", 32'(mask_o[0]), 0);
    xfer(0, 1, 24'h123456, 0, "R3 first");
    xfer(0, 1, 24'h123457, 0, "R5 second");
    xfer(0, 1, 24'h123458, 1, "R6 third");
    chk(mask_o[0] == 1'b1, "R8 self mask", 32'(mask_o[0]), 1);
    chk(tc_status_o[0] == 1'b1, "R7 sticky", 32'(tc_status_o[0]), 1);
    xfer(0, 0, 24'h0, 0, "R8 after tc");
    readback(0, 16'h3459, 16'hFFFF, "R6 R8 residue");
    chk(16'(rd_cnt_o + 16'd1) == 16'h0000, "R6 residue zero", 32'(rd_cnt_o + 16'd1), 0);
  endtask

  task automatic t_single();
    load(0, 1, 16'h0000);
    chk(tc_status_o[0] == 1'b0, "R2 count clears status", 32'(tc_status_o[0]), 0);
    set_mask(0, 1'b0);
    xfer(0, 1, 24'h123459, 1, "R6 single");
  endtask

  task automatic t_word();
    load(2, 2, 16'h0035); load(2, 0, 16'h8001); load(2, 1, 16'h0005);
    set_mask(2, 1'b0);
    xfer(2, 1, word_phys(8'h35, 16'h8001), 0, "R4 word");
    load(2, 0, 16'hFFFF);
    xfer(2, 1, word_phys(8'h35, 16'hFFFF), 0, "R4 word top");
    xfer(2, 1, word_phys(8'h35, 16'h0000), 0, "R5 word wrap");
  endtask

  task automatic t_dec();
    load(1, 3, 16'h0020); load(1, 2, 16'h0007); load(1, 0, 16'h0001); load(1, 1, 16'h0009);
    set_mask(1, 1'b0);
    xfer(1, 1, 24'h070001, 0, "R5 dec a");
    xfer(1, 1, 24'h070000, 0, "R5 dec b");
    xfer(1, 1, 24'h07FFFF, 0, "R5 dec wrap");
  endtask

  task automatic t_auto();
    load(3, 3, 16'h0010); load(3, 2, 16'h0002); load(3, 0, 16'h0100); load(3, 1, 16'h0001);
    set_mask(3, 1'b0);
    xfer(3, 1, word_phys(8'h02, 16'h0100), 0, "R9 first");
    xfer(3, 1, word_phys(8'h02, 16'h0101), 1, "R9 tc");
    chk(mask_o[3] == 1'b0, "R9 stays live", 32'(mask_o[3]), 0);
    chk(tc_status_o[3] == 1'b1, "R7 sticky ch3", 32'(tc_status_o[3]), 1);
    readback(3, 16'h0100, 16'h0001, "R9 reload");
    xfer(3, 1, word_phys(8'h02, 16'h0100), 0, "R9 again");
  endtask

  task automatic t_mask();
    set_mask(1, 1'b1);
    xfer(1, 0, 24'h0, 0, "R10 masked");
    readback(1, 16'hFFFE, 16'h0006, "R10 untouched");
    set_mask(1, 1'b0);
    xfer(1, 1, 24'h07FFFE, 0, "R10 reopened");
  endtask

  task automatic t_prio();
    @(negedge clk);
    ld_we_i = 1'b1; ld_ch_i = 2'd1; ld_sel_i = 2'd0; ld_data_i = 16'h4444;
    xfer_i = 1'b1; xfer_ch_i = 2'd1;
    @(negedge clk);
    ld_we_i = 1'b0; xfer_i = 1'b0;
    chk(phys_valid_o == 1'b0, "R11 dropped", 32'(phys_valid_o), 0);
    readback(1, 16'h4444, 16'h0005, "R11 load kept");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_byte();
    t_single();
    t_word();
    t_dec();
    t_auto();
    t_mask();
    t_prio();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule